// File: doc/BRIEF.md
# Atomic Multithreading Enable Unit

This unit owns the two enable bits that govern concurrent instruction streams in a multithreaded core. The first is a per-virtual-processor bit that permits several thread contexts to run together. The second is a processor-wide bit that permits several virtual processors to run together. It carries out four privileged operations: enable threads, disable threads, enable virtual processors and disable virtual processors.

Each operation is a single step. The step returns the full control word as it stood before the operation, for write-back to a destination general register. In the same clock edge it sets or clears the selected enable bit. No temporary register is used, and nothing can come between the read and the update, so an interrupt or a stream switch cannot observe a half-done change.

The issue stage presents one operation per cycle. The result is registered and appears one cycle later. It is either a write-back request or an exception report, and never both. The two enable bits are brought out so that the scheduler can act on them.

Top module: `mt_enable_atomic`

## Requirements
- R1: While reset is high and in the first cycle after it, `wb_en` and `exc_valid` are 0, `threads_on` is 0 and `vpes_on` is 1.
- R2: An accepted enable-threads operation (`op_code` 2'b00) returns the thread control word as it was before the operation on `wb_data`, one cycle after issue. In that same cycle `threads_on` reads 1. The thread control word is 32'h0001_0003 with bit 15 replaced by the thread-enable bit.
- R3: An accepted disable-threads operation (`op_code` 2'b01) returns the old thread control word and clears `threads_on`. Both are visible one cycle after issue.
- R4: With `master_vpe` at 1, enable-VPEs (2'b10) sets and disable-VPEs (2'b11) clears `vpes_on`. Each returns the old processor control word, which is 32'h0000_0002 with bit 0 replaced by the VPE-enable bit.
- R5: With `master_vpe` at 0, a VPE operation leaves `vpes_on` unchanged but still writes back the old processor control word.
- R6: A destination index of 0 suppresses the write-back (`wb_en` stays 0). The enable-bit update still takes place.
- R7: With `cop0_ok` at 0, an operation reports `exc_valid`=1 and `exc_code`=2 (coprocessor unusable). It writes nothing back and leaves both enable bits unchanged.
- R8: When parameter `MT_PRESENT` is 0, every operation reports `exc_code`=1 (reserved instruction), whatever the value of `cop0_ok`. It writes nothing back and changes neither bit.
- R9: Operations issued on consecutive cycles are each atomic. The second returns a word that already holds the first one's update.
- R10: In a cycle with `op_valid` at 0, the next cycle shows `wb_en`=0 and `exc_valid`=0, and neither bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is issued this cycle |
| op_code | input | 2 | 00 thread on, 01 thread off, 10 VPE on, 11 VPE off |
| op_dst | input | IDX_W | Destination register index for the old word |
| cop0_ok | input | 1 | Access to the system coprocessor is enabled |
| master_vpe | input | 1 | Issuer is allowed to change the processor-wide bit |
| wb_en | output | 1 | Write-back request, one cycle after issue |
| wb_idx | output | IDX_W | Write-back register index |
| wb_data | output | DATA_W | Control word before the operation |
| exc_valid | output | 1 | Exception report, one cycle after issue |
| exc_code | output | 2 | 0 none, 1 reserved instruction, 2 coprocessor unusable |
| threads_on | output | 1 | Per-VPE thread enable bit |
| vpes_on | output | 1 | Processor-wide VPE enable bit |

## Verification
Directed sequences first apply each opcode to each starting state of its bit. This separates the old word that is returned from the new bit value, including repeated sets and repeated clears. A pseudo-random stream then mixes idle cycles, zero destinations, coprocessor-disabled cycles and master/non-master issuers back to back. Here the per-cycle model shows whether each operation reads the outcome of the one before it. A second instance built without the feature receives the same inputs, to confirm that the reserved-instruction code wins over the coprocessor check.

// File: rtl/mt_enable_pkg.sv
package mt_enable_pkg;

    typedef enum logic [1:0] {
        OP_THR_ON  = 2'b00,
        OP_THR_OFF = 2'b01,
        OP_VPE_ON  = 2'b10,
        OP_VPE_OFF = 2'b11
    } mten_op_e;

    typedef enum logic [1:0] {
        EXC_NONE = 2'd0,
        EXC_RESV = 2'd1,
        EXC_COPU = 2'd2
    } mten_exc_e;

    localparam int NUM_CTRL = 2;
    localparam int SEL_THR  = 0;
    localparam int SEL_VPE  = 1;

    typedef struct packed {
        logic      accept;
        logic      sel_vpe;
        logic      set_val;
        logic      wb_req;
        mten_exc_e exc;
    } mten_dec_t;

    function automatic logic op_targets_vpe(mten_op_e op);
        return op[1];
    endfunction

    function automatic logic op_set_value(mten_op_e op);
        return ~op[0];
    endfunction

endpackage

// File: rtl/mten_decode.sv
module mten_decode
    import mt_enable_pkg::*;
#(
    parameter bit MT_PRESENT = 1'b1,
    parameter int IDX_W      = 5
) (
    input  logic             op_valid,
    input  mten_op_e         op,
    input  logic [IDX_W-1:0] dst,
    input  logic             cop0_ok,
    output mten_dec_t        dec
);

    mten_exc_e fault;

    always_comb begin
        fault = EXC_NONE;
        if (op_valid) begin
            if (!MT_PRESENT) begin
                fault = EXC_RESV;
            end else if (!cop0_ok) begin
                fault = EXC_COPU;
            end
        end
    end

    always_comb begin
        dec         = '0;
        dec.exc     = fault;
        dec.accept  = op_valid && (fault == EXC_NONE);
        dec.sel_vpe = op_targets_vpe(op);
        dec.set_val = op_set_value(op);
        dec.wb_req  = dec.accept && (dst != '0);
    end

endmodule

// File: rtl/mten_ctrl_reg.sv
module mten_ctrl_reg #(
    parameter int                 DATA_W  = 32,
    parameter logic [DATA_W-1:0]  CFG     = '0,
    parameter int                 BIT_POS = 0,
    parameter bit                 RST_EN  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd,
    input  logic              val,
    output logic              en,
    output logic [DATA_W-1:0] word
);

    logic en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= RST_EN;
        end else if (upd) begin
            en_q <= val;
        end
    end

    always_comb begin
        word          = CFG;
        word[BIT_POS] = en_q;
    end

    assign en = en_q;

endmodule

// File: rtl/mten_result.sv
module mten_result
    import mt_enable_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  mten_dec_t         dec,
    input  logic [IDX_W-1:0]  dst,
    input  logic [DATA_W-1:0] old_word,
    output logic              wb_en,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [DATA_W-1:0] wb_data,
    output logic              exc_valid,
    output mten_exc_e         exc_code
);

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_en     <= 1'b0;
            wb_idx    <= '0;
            wb_data   <= '0;
            exc_valid <= 1'b0;
            exc_code  <= EXC_NONE;
        end else begin
            wb_en     <= dec.wb_req;
            wb_idx    <= dec.wb_req ? dst : '0;
            wb_data   <= dec.wb_req ? old_word : '0;
            exc_valid <= (dec.exc != EXC_NONE);
            exc_code  <= dec.exc;
        end
    end

    AST_WB_EXC_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(wb_en && exc_valid)); // R7

    AST_WB_IDX_NONZERO: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (wb_idx != '0)); // R6

endmodule

// File: rtl/mt_enable_atomic.sv
module mt_enable_atomic
    import mt_enable_pkg::*;
#(
    parameter int                DATA_W     = 32,
    parameter int                IDX_W      = 5,
    parameter bit                MT_PRESENT = 1'b1,
    parameter logic [DATA_W-1:0] THR_CFG    = 32'h0001_0003,
    parameter int                THR_BIT    = 15,
    parameter bit                THR_RST    = 1'b0,
    parameter logic [DATA_W-1:0] VPE_CFG    = 32'h0000_0002,
    parameter int                VPE_BIT    = 0,
    parameter bit                VPE_RST    = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [1:0]        op_code,
    input  logic [IDX_W-1:0]  op_dst,
    input  logic              cop0_ok,
    input  logic              master_vpe,
    output logic              wb_en,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [DATA_W-1:0] wb_data,
    output logic              exc_valid,
    output logic [1:0]        exc_code,
    output logic              threads_on,
    output logic              vpes_on
);

    mten_op_e          op_e;
    mten_dec_t         dec;
    mten_exc_e         exc_e;
    logic              upd   [NUM_CTRL];
    logic              en    [NUM_CTRL];
    logic [DATA_W-1:0] word  [NUM_CTRL];
    logic [DATA_W-1:0] old_word;

    assign op_e = mten_op_e'(op_code);

    mten_decode #(
        .MT_PRESENT (MT_PRESENT),
        .IDX_W      (IDX_W)
    ) u_decode (
        .op_valid (op_valid),
        .op       (op_e),
        .dst      (op_dst),
        .cop0_ok  (cop0_ok),
        .dec      (dec)
    );

    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
        localparam bit                IS_VPE = (g == SEL_VPE);
        localparam logic [DATA_W-1:0] CFG_G  = IS_VPE ? VPE_CFG : THR_CFG;
        localparam int                POS_G  = IS_VPE ? VPE_BIT : THR_BIT;
        localparam bit                RST_G  = IS_VPE ? VPE_RST : THR_RST;

        assign upd[g] = dec.accept && (dec.sel_vpe == IS_VPE)
                        && (!IS_VPE || master_vpe);

        mten_ctrl_reg #(
            .DATA_W  (DATA_W),
            .CFG     (CFG_G),
            .BIT_POS (POS_G),
            .RST_EN  (RST_G)
        ) u_reg (
            .clk  (clk),
            .rst  (rst),
            .upd  (upd[g]),
            .val  (dec.set_val),
            .en   (en[g]),
            .word (word[g])
        );
    end

    assign old_word = dec.sel_vpe ? word[SEL_VPE] : word[SEL_THR];

    mten_result #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_result (
        .clk       (clk),
        .rst       (rst),
        .dec       (dec),
        .dst       (op_dst),
        .old_word  (old_word),
        .wb_en     (wb_en),
        .wb_idx    (wb_idx),
        .wb_data   (wb_data),
        .exc_valid (exc_valid),
        .exc_code  (exc_e)
    );

    assign exc_code   = exc_e;
    assign threads_on = en[SEL_THR];
    assign vpes_on    = en[SEL_VPE];

    AST_THR_SET: assert property (@(posedge clk) disable iff (rst)
        (MT_PRESENT && op_valid && cop0_ok && op_code == 2'b00) |=> threads_on); // R2

    AST_THR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (MT_PRESENT && op_valid && cop0_ok && op_code == 2'b01) |=> !threads_on); // R3

    AST_VPE_NONMASTER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code[1] && !master_vpe) |=> $stable(vpes_on)); // R5

    AST_COPU_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !cop0_ok) |=> (exc_valid && !wb_en
                                    && $stable(threads_on) && $stable(vpes_on))); // R7

    AST_RESV_WINS: assert property (@(posedge clk) disable iff (rst)
        (!MT_PRESENT && op_valid) |=> (exc_code == 2'd1)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (!wb_en && !exc_valid
                       && $stable(threads_on) && $stable(vpes_on))); // R10

endmodule

// File: tb/test_mt_enable_atomic.sv
`timescale 1ns/1ps
module test_mt_enable_atomic;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = 2'b00;
    logic [4:0]  op_dst = 5'd0;
    logic        cop0_ok = 1'b0;
    logic        master_vpe = 1'b0;

    logic        wb_en, a_wb_en;
    logic [4:0]  wb_idx, a_wb_idx;
    logic [31:0] wb_data, a_wb_data;
    logic        exc_valid, a_exc_valid;
    logic [1:0]  exc_code, a_exc_code;
    logic        threads_on, a_threads_on;
    logic        vpes_on, a_vpes_on;

    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;
    logic m_thr;
    logic m_vpe;

    always #2 clk = ~clk;

    mt_enable_atomic i_mt_enable_atomic (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .op_dst(op_dst), .cop0_ok(cop0_ok), .master_vpe(master_vpe),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
        .exc_valid(exc_valid), .exc_code(exc_code),
        .threads_on(threads_on), .vpes_on(vpes_on)
    );

    mt_enable_atomic #(.MT_PRESENT(1'b0)) i_mt_enable_atomic_absent (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .op_dst(op_dst), .cop0_ok(cop0_ok), .master_vpe(master_vpe),
        .wb_en(a_wb_en), .wb_idx(a_wb_idx), .wb_data(a_wb_data),
        .exc_valid(a_exc_valid), .exc_code(a_exc_code),
        .threads_on(a_threads_on), .vpes_on(a_vpes_on)
    );

    function automatic logic [31:0] thr_word(logic e);
        return (32'h0001_0003 & ~32'h0000_8000) | (32'(e) << 15);
    endfunction

    function automatic logic [31:0] vpe_word(logic e);
        return (32'h0000_0002 & ~32'h0000_0001) | 32'(e);
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(logic v, logic [1:0] op, logic [4:0] d, logic ok,
                        logic mst, string force_tag);
        logic        acc;
        logic        exp_wb;
        logic [31:0] old;
        logic [1:0]  exp_exc;
        logic        n_thr;
        logic        n_vpe;
        string       tag;
        op_valid   = v;
        op_code    = op;
        op_dst     = d;
        cop0_ok    = ok;
        master_vpe = mst;
        acc     = v && ok;
        exp_exc = (v && !ok) ? 2'd2 : 2'd0;
        exp_wb  = acc && (d != 5'd0);
        old     = op[1] ? vpe_word(m_vpe) : thr_word(m_thr);
        n_thr   = (acc && !op[1]) ? !op[0] : m_thr;
        n_vpe   = (acc && op[1] && mst) ? !op[0] : m_vpe;
        if (force_tag != "") tag = force_tag;
        else if (!v) tag = "R10";
        else if (!ok) tag = "R7";
        else if (d == 5'd0) tag = "R6";
        else if (op == 2'b00) tag = "R2";
        else if (op == 2'b01) tag = "R3";
        else if (mst) tag = "R4";
        else tag = "R5";
        @(posedge clk);
        #1;
        check(tag, "wb_en", 32'(wb_en), 32'(exp_wb));
        check(tag, "exc_valid", 32'(exc_valid), 32'(exp_exc != 2'd0));
        check(tag, "exc_code", 32'(exc_code), 32'(exp_exc));
        if (exp_wb) begin
            check(tag, "wb_idx", 32'(wb_idx), 32'(d));
            check(tag, "wb_data", wb_data, old);
        end
        check(tag, "threads_on", 32'(threads_on), 32'(n_thr));
        check(tag, "vpes_on", 32'(vpes_on), 32'(n_vpe));
        // R8: build without the feature faults every issued operation
        check("R8", "absent exc_code", 32'(a_exc_code), v ? 32'd1 : 32'd0);
        check("R8", "absent wb_en", 32'(a_wb_en), 32'd0);
        check("R8", "absent threads_on", 32'(a_threads_on), 32'd0);
        check("R8", "absent vpes_on", 32'(a_vpes_on), 32'd1);
        m_thr = n_thr;
        m_vpe = n_vpe;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R10 watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        m_thr = 1'b0;
        m_vpe = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "reset wb_en", 32'(wb_en), 32'd0);
        check("R1", "reset exc_valid", 32'(exc_valid), 32'd0);
        check("R1", "reset threads_on", 32'(threads_on), 32'd0);
        check("R1", "reset vpes_on", 32'(vpes_on), 32'd1);
        rst = 1'b0;
        step(1'b0, 2'b00, 5'd0, 1'b1, 1'b1, "R1");

        step(1'b1, 2'b00, 5'd3,  1'b1, 1'b0, "");    // R2 set from 0
        step(1'b1, 2'b00, 5'd4,  1'b1, 1'b0, "");    // R2 set again
        step(1'b1, 2'b01, 5'd7,  1'b1, 1'b0, "");    // R3 clear
        step(1'b1, 2'b01, 5'd8,  1'b1, 1'b0, "");    // R3 clear again
        step(1'b1, 2'b11, 5'd9,  1'b1, 1'b1, "");    // R4 clear
        step(1'b1, 2'b10, 5'd10, 1'b1, 1'b1, "");    // R4 set
        step(1'b1, 2'b11, 5'd11, 1'b1, 1'b0, "");    // R5 no change
        step(1'b1, 2'b00, 5'd0,  1'b1, 1'b1, "");    // R6 update, no wb
        step(1'b1, 2'b01, 5'd5,  1'b0, 1'b1, "");    // R7
        step(1'b1, 2'b11, 5'd5,  1'b0, 1'b1, "");    // R7
        step(1'b0, 2'b01, 5'd6,  1'b1, 1'b1, "");    // R10
        step(1'b1, 2'b01, 5'd12, 1'b1, 1'b1, "R9");
        step(1'b1, 2'b00, 5'd13, 1'b1, 1'b1, "R9");
        step(1'b1, 2'b11, 5'd14, 1'b1, 1'b1, "R9");
        step(1'b1, 2'b11, 5'd15, 1'b1, 1'b1, "R9");

        lf = 16'hACE1;
        for (int i = 0; i < 80; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[0] | lf[1], lf[3:2], lf[8:4], lf[9] | lf[10], lf[11], "");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule